// File: doc/BRIEF.md
# Memory Command Rate Throttler

This block sits on a valid/ready command path between a command source and a memory controller and holds down memory power by limiting how many commands pass in any stretch of 100 clock cycles. The clock is never touched; the block simply withholds `up_ready` and `dn_valid` once the commands granted inside the current 100-cycle window have used up the allowance.

Two independent control paths set the throttle percentage. One path follows a thermal alert input from memory module temperature sensors and applies a programmed thermal level while the alert is high. The other is a software level that stays in force regardless of the alert. Each nonzero level is clamped into the 30 to 95 percent range. When both paths are active, the larger percentage applies. The number of commands allowed per window is 100 minus that percentage.

Top module: `cmd_rate_throttler`

## Requirements
- R1: `dn_data` always equals `up_data`; `dn_valid` is `up_valid` AND the open gate; `up_ready` is `dn_ready` AND the open gate.
- R2: A command counts as issued only in a cycle where `up_valid` and `up_ready` are both 1; cycles without such a handshake add nothing to the window count.
- R3: While the effective percentage P is nonzero and constant, no 100 consecutive cycles contain more than 100 − P issued commands.
- R4: The gate closes (`up_ready` = 0 and `dn_valid` = 0) exactly when P is nonzero and the number of commands issued in the previous 100 cycles is at least 100 − P. Otherwise the gate is open.
- R5: A software level of 0 disables the software path. With the thermal alert low as well, every cycle is open.
- R6: A nonzero software level below 30 acts as 30, and a level above 95 acts as 95.
- R7: While `therm_alert` is 1, the thermal level is applied, clamped to 30..95. A level of 0 acts as 30. While `therm_alert` is 0, `therm_level` has no effect.
- R8: When both paths are active, the larger of the two clamped percentages applies.
- R9: After a synchronous active-low reset the window history is empty, so the gate is open.
- R10: A change of percentage does not clear the window; commands already issued in the last 100 cycles still count against the new allowance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Command offered by the source |
| up_data | input | DATA_W | Command payload from the source |
| up_ready | output | 1 | Command accepted this cycle if valid |
| dn_valid | output | 1 | Command presented to the memory controller |
| dn_data | output | DATA_W | Command payload to the controller |
| dn_ready | input | 1 | Controller can take a command |
| therm_alert | input | 1 | Thermal alert from memory module sensors |
| therm_level | input | PCT_W | Throttle percentage used during an alert |
| sw_level | input | PCT_W | Software throttle percentage, 0 = off |

## Verification
Two functions can act in the same cycle: a change of the effective percentage and the window limit on a handshake. They meet when the bench switches levels while a saturating source has filled part of the window. It also does so while the controller drops `dn_ready` at intervals. The bench keeps its own 100-cycle record of observed handshakes and checks `up_ready` and `dn_valid` against the allowance computed from the new percentage and that record, every cycle. A scoreboard queue confirms that each accepted payload arrives in order.

// File: rtl/cmdthr_pkg.sv
// Shared constants and helpers for the command rate throttler.
// Assumes percentages are unsigned integers of PCT_W bits.
package cmdthr_pkg;
    localparam int PCT_W   = 7;
    localparam int MIN_PCT = 30;
    localparam int MAX_PCT = 95;

    typedef logic [PCT_W-1:0] pct_t;

    // Force a percentage into the legal throttle range.
    function automatic pct_t clamp_pct(input pct_t v);
        if (v < pct_t'(MIN_PCT))      return pct_t'(MIN_PCT);
        else if (v > pct_t'(MAX_PCT)) return pct_t'(MAX_PCT);
        else                          return v;
    endfunction
endpackage

// File: rtl/cmdthr_select.sv
// Chooses the effective throttle percentage from the thermal and software
// paths and derives the per-window command allowance.
// Assumes: sw_level 0 means software path off; thermal path is active only
// while therm_alert is high; the larger clamped percentage wins.
module cmdthr_select
    import cmdthr_pkg::*;
#(
    parameter int WINDOW = 100,
    parameter int CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             therm_alert,
    input  pct_t             therm_level,
    input  pct_t             sw_level,
    output pct_t             pct,
    output logic [CNT_W-1:0] allowed
);
    pct_t sw_pct;
    pct_t th_pct;

    // Resolve each path to a clamped percentage or zero when inactive.
    always_comb begin
        sw_pct = (sw_level == '0) ? '0 : clamp_pct(sw_level);
        th_pct = therm_alert ? clamp_pct(therm_level) : '0;
    end

    // Stronger throttle wins; allowance scales the window by the remaining share.
    always_comb begin
        pct     = (th_pct > sw_pct) ? th_pct : sw_pct;
        allowed = CNT_W'((WINDOW * (100 - int'(pct))) / 100);
    end

    AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pct == '0) || (pct >= pct_t'(MIN_PCT) && pct <= pct_t'(MAX_PCT))); // R6
    AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!therm_alert && sw_level == '0) |-> (pct == '0)); // R5
    AST_ALERT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        therm_alert |-> (pct >= pct_t'(MIN_PCT))); // R7
endmodule

// File: rtl/cmdthr_window.sv
// Sliding record of issued-command flags over the last WINDOW cycles with
// a running population count.
// Assumes WINDOW >= 2 and that issue is a single-cycle handshake flag.
module cmdthr_window #(
    parameter int WINDOW = 100,
    parameter int CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    output logic [CNT_W-1:0] count
);
    logic [WINDOW-1:0] hist;
    logic              oldest;

    // The flag leaving the window this cycle.
    always_comb oldest = hist[WINDOW-1];

    // Shift in the new flag and adjust the count by entry minus exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= '0;
            count <= '0;
        end else begin
            hist  <= {hist[WINDOW-2:0], issue};
            count <= count + CNT_W'(issue) - CNT_W'(oldest);
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(WINDOW)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1)
        || (count + 1'b1 == $past(count))); // R2
    AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (count <= $past(count))); // R2
endmodule

// File: rtl/cmd_rate_throttler.sv
// Top of the command rate throttler: gates a valid/ready command path so
// that at most (100 - pct)% of any WINDOW-cycle span carries a command.
// Assumes the downstream controller obeys valid/ready; payload passes through.
module cmd_rate_throttler
    import cmdthr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WINDOW = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_ready,
    input  logic              therm_alert,
    input  logic [PCT_W-1:0]  therm_level,
    input  logic [PCT_W-1:0]  sw_level
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    pct_t             pct;
    logic [CNT_W-1:0] allowed;
    logic [CNT_W-1:0] count;
    logic             gate_open;
    logic             issue;

    cmdthr_select #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_select (
        .clk(clk), .rst_n(rst_n), .therm_alert(therm_alert),
        .therm_level(therm_level), .sw_level(sw_level),
        .pct(pct), .allowed(allowed)
    );

    cmdthr_window #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_window (
        .clk(clk), .rst_n(rst_n), .issue(issue), .count(count)
    );

    // Gate stays open while throttling is off or allowance remains.
    always_comb gate_open = (pct == '0) || (count < allowed);

    // Handshake gating and payload pass-through.
    always_comb begin
        up_ready = dn_ready & gate_open;
        dn_valid = up_valid & gate_open;
        dn_data  = up_data;
        issue    = up_valid & up_ready;
    end

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && pct != '0) |-> (count < allowed)); // R3
    AST_DN_NEEDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> up_valid); // R1
    AST_HS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready) == (up_valid && up_ready)); // R1
    AST_RESET_OPEN: assert property (@(posedge clk)
        !rst_n |=> up_ready == dn_ready); // R9
endmodule

// File: tb/cmd_rate_throttler_tb.sv
module cmd_rate_throttler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              up_valid = 0;
    logic [DATA_W-1:0] up_data = '0;
    logic              up_ready;
    logic              dn_valid;
    logic [DATA_W-1:0] dn_data;
    logic              dn_ready = 1;
    logic              therm_alert = 0;
    logic [6:0]        therm_level = '0;
    logic [6:0]        sw_level = '0;

    cmd_rate_throttler u_dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
        .up_ready(up_ready), .dn_valid(dn_valid), .dn_data(dn_data),
        .dn_ready(dn_ready), .therm_alert(therm_alert),
        .therm_level(therm_level), .sw_level(sw_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int phase_cyc = 0;
    bit done = 0;
    bit acc  = 0;
    string cur_req = "R9";
    logic [DATA_W-1:0] exp_q[$];
    logic [99:0] hist = '0;
    int wcnt = 0;
    logic [DATA_W-1:0] seq = 1;

    function automatic int clamp(input int v);
        return (v < 30) ? 30 : (v > 95) ? 95 : v;
    endfunction

    // Effective percentage from R5..R8.
    function automatic int model_pct();
        int s = (sw_level == 0) ? 0 : clamp(int'(sw_level));
        int t = therm_alert ? clamp(int'(therm_level)) : 0;
        return (t > s) ? t : s;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: compare outputs at the falling edge, then advance the window model.
    always @(negedge clk) begin
        if (rst_n) begin
            int p, allow;
            bit gate, hs;
            p     = model_pct();
            allow = 100 - p;
            gate  = (p == 0) || (wcnt < allow);
            check(up_ready == (dn_ready && gate), cur_req, "up_ready (R4)",
                  up_ready, dn_ready && gate);
            check(dn_valid == (up_valid && gate), cur_req, "dn_valid (R1)",
                  dn_valid, up_valid && gate);
            hs = up_valid && up_ready;
            if (hs) begin
                if (exp_q.size() == 0)
                    check(0, "R1", "unexpected handshake", 1, 0);
                else begin
                    check(dn_data == exp_q[0], "R1", "payload", int'(dn_data), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
            end
            wcnt = wcnt + int'(hs) - int'(hist[99]);
            hist = {hist[98:0], hs};
            if (phase_cyc >= 100 && p != 0)
                check(wcnt <= allow, "R3", "issues in window", wcnt, allow);
            acc = hs;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    // Driver: set levels, then offer commands; each new item enters the scoreboard.
    task automatic run_phase(input int sw, input bit al, input int th, input int n,
                             input int vmode, input int rmode, input string req);
        phase_cyc = 0;
        for (int i = 0; i < n; i++) begin
            bit nv;
            @(posedge clk); #1;
            if (i == 0) begin
                sw_level = 7'(sw); therm_alert = al; therm_level = 7'(th); cur_req = req;
            end
            phase_cyc++;
            dn_ready = (rmode == 0) ? 1'b1 : ((i % 7) != 3);
            if (!(up_valid && !acc)) begin
                nv = (vmode == 0) ? 1'b1 : ((i % 3) == 0);
                if (nv) begin
                    up_data = seq; exp_q.push_back(seq); seq++;
                end
                up_valid = nv;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(up_ready == 1'b1, "R9", "up_ready after reset", up_ready, 1);
        check(dn_valid == 1'b0, "R9", "dn_valid after reset", dn_valid, 0);
        run_phase(0,   0, 90, 150, 0, 0, "R5");
        run_phase(50,  0, 0,  250, 0, 0, "R4");
        run_phase(10,  0, 0,  250, 0, 1, "R6");
        run_phase(120, 0, 0,  250, 0, 0, "R6");
        run_phase(40,  0, 0,  60,  0, 0, "R10");
        run_phase(0,   1, 60, 250, 0, 0, "R7");
        run_phase(0,   1, 0,  200, 0, 0, "R7");
        run_phase(0,   0, 90, 150, 0, 0, "R7");
        run_phase(40,  1, 80, 250, 0, 1, "R8");
        run_phase(90,  1, 40, 250, 0, 0, "R8");
        run_phase(50,  0, 0,  300, 1, 1, "R2");
        @(posedge clk); #1 up_valid = 0;
        repeat (3) @(posedge clk);
        check(exp_q.size() <= 1, "R1", "scoreboard leftover", exp_q.size(), 0);
        summary();
    end
endmodule